// File: doc/BRIEF.md
# I2C Temperature Sensor Target

This block is the register side of a temperature sensor that sits on an I2C bus as a target. A bit-level engine, outside the block, handles the pins and reports start conditions, stop conditions, the received address byte, each received data byte and the end of each transmitted byte, with the master's acknowledge or not-acknowledge. The block decides whether it is addressed, returns an acknowledge, and serves bytes out of a small register file that a pointer selects.

There are four registers. One holds the temperature and is driven from an input port. One is an 8-bit configuration register. Two are 16-bit limit registers, low and high. A write transaction always begins with a pointer byte. Any data bytes that follow load the selected register. A read transaction returns the selected register, with a 16-bit register sent most significant byte first. The pointer keeps its value across stops, new transactions and repeated starts. A master can therefore set it once and then read the same register many times.

Top module: `tmp_sensor_target`

## Requirements
- R1: The target responds only to the 7-bit address 0x48. An address byte with any other value gets no acknowledge. It leaves the target deselected, so later data bytes are neither acknowledged nor stored.
- R2: The first data byte after a matching write address is the pointer. Only its two low bits are kept: 0 selects temperature, 1 configuration, 2 low limit and 3 high limit. A write carrying only the pointer byte changes no register.
- R3: The configuration register is 8 bits wide. Each data byte written with pointer 1 replaces it. Every byte read with pointer 1 returns its current value.
- R4: The low and high limit registers are 16 bits wide. Data bytes written to them alternate: most significant byte first, then least significant byte. They read back in that same order.
- R5: The temperature register reads as two bytes of temp_i, most significant byte first. Data bytes written with pointer 0 are acknowledged and discarded.
- R6: The pointer keeps its value across stop conditions, fresh starts, repeated starts and read transactions.
- R7: Within one read transaction of a 16-bit register, the byte position alternates high, low, high and so on. After the low byte it wraps back to the high byte.
- R8: After reset the pointer is 0, configuration is 0x00, the low limit is 0x4B00 and the high limit is 0x5000.
- R9: ack_o pulses high for exactly one cycle, in the cycle after a matching address byte or after any data byte received while the target is selected for writing. It is low at all other times.
- R10: rd_en_o is high while the target is selected for reading. It drops in the cycle after the master answers a read byte with not-acknowledge, or after a stop or start.
- R11: A stop strobe that arrives in the same cycle as a data byte does not lose the byte. The byte is acknowledged and stored, and the target is deselected afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen (one-cycle strobe) |
| stop_i | input | 1 | Stop seen (one-cycle strobe) |
| addr_stb_i | input | 1 | Address byte received (one-cycle strobe) |
| addr_i | input | 7 | Received 7-bit address |
| rnw_i | input | 1 | Direction bit of the address byte, 1 = read |
| wbyte_stb_i | input | 1 | Data byte received from master (one-cycle strobe) |
| wbyte_i | input | 8 | Received data byte |
| rd_done_i | input | 1 | Transmitted byte finished, master response valid |
| mnack_i | input | 1 | Master not-acknowledge on that byte |
| temp_i | input | 16 | Current temperature value |
| ack_o | output | 1 | Acknowledge request to the bit engine |
| rd_en_o | output | 1 | Target is driving read data |
| rd_data_o | output | 8 | Byte to transmit next |

## Verification
Two events can share one clock edge. The first pair is a stop strobe together with a received data byte. The bench drives both in the same cycle with pointer 1 and value 0x3C. It expects an acknowledge in the next cycle and a deselected target. A later read must return 0x3C. The second pair is a master not-acknowledge on a read byte together with the byte-position update. The bench checks that rd_en_o falls, and that the next read transaction still starts at the high byte.

// File: rtl/tmp_sensor_target.sv
module tmp_sensor_target #(
  parameter logic [6:0]  ADDR      = 7'h48,
  parameter logic [7:0]  CFG_RST   = 8'h00,
  parameter logic [15:0] TLOW_RST  = 16'h4B00,
  parameter logic [15:0] THIGH_RST = 16'h5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        addr_stb_i,
  input  logic [6:0]  addr_i,
  input  logic        rnw_i,
  input  logic        wbyte_stb_i,
  input  logic [7:0]  wbyte_i,
  input  logic        rd_done_i,
  input  logic        mnack_i,
  input  logic [15:0] temp_i,
  output logic        ack_o,
  output logic        rd_en_o,
  output logic [7:0]  rd_data_o
);
  localparam logic [1:0] P_TEMP = 2'd0, P_CFG = 2'd1, P_LOW = 2'd2, P_HIGH = 2'd3;

  logic        sel_q, rd_q, need_ptr_q, wcnt_q, rcnt_q, ack_q;
  logic [1:0]  ptr_q;
  logic [7:0]  cfg_q;
  logic [15:0] low_q, high_q;

  wire wr_take = sel_q & ~rd_q & wbyte_stb_i;
  wire rd_take = sel_q &  rd_q & rd_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      rd_q       <= 1'b0;
      need_ptr_q <= 1'b0;
      wcnt_q     <= 1'b0;
      rcnt_q     <= 1'b0;
      ack_q      <= 1'b0;
      ptr_q      <= P_TEMP;
      cfg_q      <= CFG_RST;
      low_q      <= TLOW_RST;
      high_q     <= THIGH_RST;
    end else begin
      ack_q <= 1'b0;
      if (addr_stb_i) begin
        if (addr_i == ADDR) begin
          sel_q      <= 1'b1;
          rd_q       <= rnw_i;
          need_ptr_q <= ~rnw_i;
          wcnt_q     <= 1'b0;
          rcnt_q     <= 1'b0;
          ack_q      <= 1'b1;
        end else begin
          sel_q <= 1'b0;
        end
      end else if (start_i || stop_i) begin
        sel_q <= 1'b0;
      end
      if (wr_take) begin
        ack_q <= 1'b1;
        if (need_ptr_q) begin
          ptr_q      <= wbyte_i[1:0];
          need_ptr_q <= 1'b0;
        end else begin
          wcnt_q <= ~wcnt_q;
          case (ptr_q)
            P_CFG:  cfg_q <= wbyte_i;
            P_LOW:  if (wcnt_q) low_q[7:0]  <= wbyte_i; else low_q[15:8]  <= wbyte_i;
            P_HIGH: if (wcnt_q) high_q[7:0] <= wbyte_i; else high_q[15:8] <= wbyte_i;
            default: ;
          endcase
        end
      end
      if (rd_take) begin
        if (mnack_i) sel_q <= 1'b0;
        else if (ptr_q != P_CFG) rcnt_q <= ~rcnt_q;
      end
    end
  end

  logic [15:0] word;
  always_comb begin
    case (ptr_q)
      P_TEMP:  word = temp_i;
      P_LOW:   word = low_q;
      P_HIGH:  word = high_q;
      default: word = {cfg_q, cfg_q};
    endcase
  end

  assign rd_data_o = rcnt_q ? word[7:0] : word[15:8];
  assign rd_en_o   = sel_q & rd_q;
  assign ack_o     = ack_q;
endmodule

module tmp_sensor_target_chk #(
  parameter logic [6:0] ADDR = 7'h48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       stop_i,
  input logic       addr_stb_i,
  input logic [6:0] addr_i,
  input logic       wbyte_stb_i,
  input logic       rd_done_i,
  input logic       mnack_i,
  input logic       ack_o,
  input logic       rd_en_o,
  input logic [1:0] ptr_q
);
  // R9
  ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(addr_stb_i || wbyte_stb_i));
  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && !addr_stb_i && !wbyte_stb_i |=> !ack_o);
  // R1
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb_i && addr_i != ADDR |=> !ack_o && !rd_en_o);
  // R10
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o && rd_done_i && mnack_i && !addr_stb_i |=> !rd_en_o);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i || start_i) && !addr_stb_i |=> !rd_en_o);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wbyte_stb_i |=> $stable(ptr_q));
endmodule

bind tmp_sensor_target tmp_sensor_target_chk #(.ADDR(ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .addr_stb_i(addr_stb_i), .addr_i(addr_i), .wbyte_stb_i(wbyte_stb_i),
  .rd_done_i(rd_done_i), .mnack_i(mnack_i), .ack_o(ack_o),
  .rd_en_o(rd_en_o), .ptr_q(ptr_q)
);

// File: tb/tb_tmp_sensor_target.sv
module tb_tmp_sensor_target;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, addr_stb_i = 0, rnw_i = 0;
  logic wbyte_stb_i = 0, rd_done_i = 0, mnack_i = 0;
  logic [6:0]  addr_i = 0;
  logic [7:0]  wbyte_i = 0;
  logic [15:0] temp_i = 0;
  logic        ack_o, rd_en_o;
  logic [7:0]  rd_data_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmp_sensor_target dut (.*);

  // {pointer, data byte count, d0, d1, expected MSB, expected LSB}; temp_i = 0
  localparam logic [47:0] VEC [8] = '{
    48'h00_00_00_00_00_00,  // R5 temperature zero
    48'h01_01_00_00_00_00,  // R3 config written 0x00
    48'h02_02_12_34_12_34,  // R4 low limit
    48'h03_02_42_31_42_31,  // R4 high limit
    48'h01_01_A5_00_A5_A5,  // R3 config repeated byte
    48'h06_00_00_00_12_34,  // R2 pointer low bits, pointer-only write
    48'h00_02_FF_FF_00_00,  // R5 write to temperature discarded
    48'h03_00_00_00_42_31   // R6 pointer persists
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask

  task automatic do_addr(input logic [6:0] a, input logic rnw, input logic exp_ack, input string tag);
    @(negedge clk) begin addr_stb_i = 1; addr_i = a; rnw_i = rnw; end
    @(negedge clk) addr_stb_i = 0;
    check(ack_o == exp_ack, tag, ack_o, exp_ack);
  endtask

  task automatic do_wr(input logic [7:0] b, input logic exp_ack, input string tag);
    @(negedge clk) begin wbyte_stb_i = 1; wbyte_i = b; end
    @(negedge clk) wbyte_stb_i = 0;
    check(ack_o == exp_ack, tag, ack_o, exp_ack);
  endtask

  task automatic rd_byte(input logic [7:0] exp, input logic last, input string tag);
    check(rd_data_o == exp, tag, rd_data_o, exp);
    rd_done_i = 1; mnack_i = last;
    @(negedge clk) begin rd_done_i = 0; mnack_i = 0; end
    if (last) check(rd_en_o == 1'b0, {tag, " R10 release"}, rd_en_o, 0);
  endtask

  task automatic write_txn(input logic [7:0] p, input int n, input logic [7:0] d0, input logic [7:0] d1);
    do_start();
    do_addr(7'h48, 0, 1, "R1 write addr ack");
    do_wr(p, 1, "R9 pointer ack");
    if (n > 0) do_wr(d0, 1, "R9 data ack");
    if (n > 1) do_wr(d1, 1, "R9 data ack");
    do_stop();
  endtask

  task automatic read2(input logic [7:0] e0, input logic [7:0] e1, input string tag);
    do_start();
    do_addr(7'h48, 1, 1, "R1 read addr ack");
    check(rd_en_o == 1'b1, "R10 rd_en high", rd_en_o, 1);
    rd_byte(e0, 0, tag);
    rd_byte(e1, 1, tag);
    do_stop();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ack_o == 0 && rd_en_o == 0, "R8 reset outputs idle", {ack_o, rd_en_o}, 0);

    // R8 reset pointer 0 selects temperature, R5 MSB first
    temp_i = 16'hABCD;
    read2(8'hAB, 8'hCD, "R8 R5 temperature after reset");
    write_txn(8'h02, 0, 0, 0);
    read2(8'h4B, 8'h00, "R8 low limit reset");
    write_txn(8'h03, 0, 0, 0);
    read2(8'h50, 8'h00, "R8 high limit reset");
    write_txn(8'h01, 0, 0, 0);
    read2(8'h00, 8'h00, "R8 config reset");
    temp_i = 16'h0000;

    foreach (VEC[i]) begin
      write_txn(VEC[i][47:40], int'(VEC[i][39:32]), VEC[i][31:24], VEC[i][23:16]);
      read2(VEC[i][15:8], VEC[i][7:0], $sformatf("R2 R3 R4 R5 vector %0d", i));
    end

    // R7 wrap within one read: high, low, high
    write_txn(8'h02, 0, 0, 0);
    do_start();
    do_addr(7'h48, 1, 1, "R1 read addr ack");
    rd_byte(8'h12, 0, "R7 first");
    rd_byte(8'h34, 0, "R7 second");
    rd_byte(8'h12, 1, "R7 wrapped");
    do_stop();

    // R1 foreign address: no ack, bytes ignored
    do_start();
    do_addr(7'h49, 0, 0, "R1 foreign addr no ack");
    do_wr(8'h01, 0, "R1 foreign pointer no ack");
    do_wr(8'h77, 0, "R1 foreign data no ack");
    do_stop();
    read2(8'h12, 8'h34, "R1 foreign write ignored");

    // R6 repeated start keeps pointer
    do_start();
    do_addr(7'h48, 0, 1, "R6 write addr");
    do_wr(8'h03, 1, "R6 pointer");
    do_start();
    do_addr(7'h48, 1, 1, "R6 read addr after repeated start");
    rd_byte(8'h42, 0, "R6 repeated start MSB");
    rd_byte(8'h31, 1, "R6 repeated start LSB");
    do_stop();

    // R10 stop releases read drive
    do_start();
    do_addr(7'h48, 1, 1, "R10 read addr");
    do_stop();
    check(rd_en_o == 0, "R10 stop release", rd_en_o, 0);

    // R11 stop coincident with a data byte
    do_start();
    do_addr(7'h48, 0, 1, "R11 addr");
    do_wr(8'h01, 1, "R11 pointer");
    @(negedge clk) begin wbyte_stb_i = 1; wbyte_i = 8'h3C; stop_i = 1; end
    @(negedge clk) begin wbyte_stb_i = 0; stop_i = 0; end
    check(ack_o == 1, "R11 ack with stop", ack_o, 1);
    do_wr(8'h55, 0, "R11 deselected after stop");
    read2(8'h3C, 8'h3C, "R11 byte stored");

    // R5 temperature follows input, R2 pointer 4 -> 0
    write_txn(8'h04, 0, 0, 0);
    temp_i = 16'h1F80;
    read2(8'h1F, 8'h80, "R5 R2 temperature via pointer 4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule